// File: doc/BRIEF.md
# Atomic Lock-Byte and Swap Sequencer

This block carries out the two indivisible read-modify-write operations of a 32-bit core. The lock-byte operation fetches one unsigned byte, returns it zero-extended as the register result and leaves 0xFF in that byte of memory. The swap operation exchanges a register word with a memory word. Either operation may be issued against the normal space or the alternate space. The alternate space is reserved for supervisor code.

A request carries the operation, the space flag, the address and the register value. The sequencer first raises a bus request and waits for the arbiter's grant. It then holds a lock line from the start of its read until its write is acknowledged, so no other master can slip an access between the two. When it finishes, it presents the old memory value, or a trap code, for one cycle. Requests that arrive while it is busy are refused.

Top module: `atomic_seq`

## Requirements
- R1: A lock-byte operation returns the addressed byte zero-extended. Byte lanes are big-endian: address offset k maps to data bits [31-8k:24-8k] and to mem_be bit 3-k. The write asserts only that one byte enable and puts 0xFF in that byte; the other bytes of the word are left unchanged.
- R2: A swap returns the old memory word and writes the request's register value to the same word, with mem_be = 4'b1111.
- R3: mem_lock is high on every cycle in which mem_rd or mem_wr is high. The write starts on the cycle right after the read is acknowledged without error. mem_lock falls after the write acknowledge. Exactly one write happens for each operation that completes without a trap.
- R4: mem_req is held high while the block waits for a grant. mem_rd is raised only on the cycle after mem_gnt was seen high.
- R5: An alternate-space request (req_alt=1) made with supervisor=0 completes with rsp_trap=1 and rsp_wr=0, and it makes no memory access.
- R6: A swap whose address bits [1:0] are not zero completes with rsp_trap=2, rsp_wr=0 and no memory access. A lock-byte operation never raises this trap. When both traps apply, the privilege trap (code 1) is reported.
- R7: If the read returns mem_err, no write is issued and the lock is released. The operation completes with rsp_trap=3, rsp_wr=0 and rsp_data=0, and memory is unchanged.
- R8: busy goes high on the edge that accepts a request and stays high through the single-cycle rsp_valid pulse. req_valid is ignored while busy is high, so it produces no memory access and no extra response.
- R9: During and after reset, busy, mem_req, mem_lock, mem_rd, mem_wr and rsp_valid are low.
- R10: A successful operation returns rsp_trap=0 and rsp_wr=1. req_op encodes the operation as 0 for lock-byte and 1 for swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request, taken only while busy is low |
| req_op | input | 1 | 0 = lock-byte, 1 = swap |
| req_alt | input | 1 | Alternate address space |
| req_addr | input | 32 | Byte address |
| req_data | input | 32 | Register value to swap in |
| supervisor | input | 1 | Processor is in privileged mode |
| busy | output | 1 | Operation in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_wr | output | 1 | Destination register is to be written |
| rsp_trap | output | 2 | 0 none, 1 privilege, 2 alignment, 3 access error |
| rsp_data | output | 32 | Old memory value for the register |
| mem_req | output | 1 | Bus request to the arbiter |
| mem_gnt | input | 1 | Bus grant |
| mem_lock | output | 1 | Bus lock held across read and write |
| mem_rd | output | 1 | Read strobe, held until mem_ack |
| mem_wr | output | 1 | Write strobe, held until mem_ack |
| mem_alt | output | 1 | Space flag for the access |
| mem_addr | output | 32 | Access address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access acknowledge, one cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_err | input | 1 | Read failed, valid with mem_ack |

## Verification
The assertions assume a memory port that answers each strobe with exactly one single-cycle mem_ack. They also assume that mem_ack is low on the cycle after an acknowledge and that mem_err is meaningful only together with mem_ack. The bench memory model holds to this: it drops mem_ack for a cycle after each acknowledge, adds a random latency of zero to two cycles, and raises mem_err only on read acknowledges when an error is armed. The grant is driven only in answer to mem_req, after a random delay. Random requests mix aligned and misaligned addresses, both spaces and both privilege levels. During each operation a stray request is pushed in to show that it is refused.

// File: rtl/atomic_pkg.sv
package atomic_pkg;
  typedef enum logic [1:0] {
    TRAP_NONE   = 2'd0,
    TRAP_PRIV   = 2'd1,
    TRAP_ALIGN  = 2'd2,
    TRAP_ACCESS = 2'd3
  } trap_e;

  typedef enum logic {
    OP_LOCKBYTE = 1'b0,
    OP_XCHG     = 1'b1
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GRANT,
    ST_READ,
    ST_WRITE,
    ST_RELEASE,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/atomic_trap_decode.sv
module atomic_trap_decode
  import atomic_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic             alt,
  input  logic             priv,
  input  logic             op,
  input  logic [OFF_W-1:0] offset,
  output trap_e            trap
);
  // privilege outranks alignment
  always_comb begin
    if (alt && !priv)
      trap = TRAP_PRIV;
    else if (op == OP_XCHG && offset != '0)
      trap = TRAP_ALIGN;
    else
      trap = TRAP_NONE;
  end
endmodule

// File: rtl/atomic_lane.sv
module atomic_lane
  import atomic_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              op,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] rd_word,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] result
);
  // big-endian: offset 0 is the most significant lane
  logic [OFF_W-1:0] lane_idx;
  assign lane_idx = OFF_W'(LANES - 1) - offset;

  always_comb begin
    be     = '0;
    result = '0;
    if (op == OP_XCHG) begin
      be     = '1;
      wdata  = reg_val;
      result = rd_word;
    end else begin
      wdata = '1;
      for (int i = 0; i < LANES; i++) begin
        if (lane_idx == OFF_W'(i)) begin
          be[i]       = 1'b1;
          result[7:0] = rd_word[8*i +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/atomic_seq.sv
module atomic_seq
  import atomic_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_op,
  input  logic              req_alt,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              supervisor,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_wr,
  output logic [1:0]        rsp_trap,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic              mem_lock,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              mem_alt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_err
);
  seq_state_e        state;
  logic              cap_op;
  logic              cap_alt;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic [DATA_W-1:0] old_q;
  logic              err_q;
  trap_e             trap_c;
  logic [DATA_W-1:0] lane_res;

  atomic_trap_decode #(.OFF_W(OFF_W)) u_trap (
    .alt    (req_alt),
    .priv   (supervisor),
    .op     (req_op),
    .offset (req_addr[OFF_W-1:0]),
    .trap   (trap_c)
  );

  atomic_lane #(.DATA_W(DATA_W)) u_lane (
    .op      (cap_op),
    .offset  (cap_addr[OFF_W-1:0]),
    .reg_val (cap_data),
    .rd_word (mem_rdata),
    .be      (mem_be),
    .wdata   (mem_wdata),
    .result  (lane_res)
  );

  assign mem_addr = cap_addr;
  assign mem_alt  = cap_alt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_wr    <= 1'b0;
      rsp_trap  <= TRAP_NONE;
      rsp_data  <= '0;
      mem_req   <= 1'b0;
      mem_lock  <= 1'b0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      cap_op    <= 1'b0;
      cap_alt   <= 1'b0;
      cap_addr  <= '0;
      cap_data  <= '0;
      old_q     <= '0;
      err_q     <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cap_op   <= req_op;
            cap_alt  <= req_alt;
            cap_addr <= req_addr;
            cap_data <= req_data;
            busy     <= 1'b1;
            if (trap_c != TRAP_NONE) begin
              rsp_valid <= 1'b1;
              rsp_trap  <= trap_c;
              rsp_wr    <= 1'b0;
              rsp_data  <= '0;
              state     <= ST_DONE;
            end else begin
              mem_req <= 1'b1;
              state   <= ST_GRANT;
            end
          end
        end
        ST_GRANT: begin
          if (mem_gnt) begin
            mem_lock <= 1'b1;
            mem_rd   <= 1'b1;
            state    <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ack) begin
            mem_rd <= 1'b0;
            if (mem_err) begin
              err_q    <= 1'b1;
              mem_lock <= 1'b0;
              mem_req  <= 1'b0;
              state    <= ST_RELEASE;
            end else begin
              err_q  <= 1'b0;
              old_q  <= lane_res;
              mem_wr <= 1'b1;
              state  <= ST_WRITE;
            end
          end
        end
        ST_WRITE: begin
          if (mem_ack) begin
            mem_wr   <= 1'b0;
            mem_lock <= 1'b0;
            mem_req  <= 1'b0;
            state    <= ST_RELEASE;
          end
        end
        ST_RELEASE: begin
          rsp_valid <= 1'b1;
          rsp_wr    <= !err_q;
          rsp_trap  <= err_q ? TRAP_ACCESS : TRAP_NONE;
          rsp_data  <= err_q ? '0 : old_q;
          state     <= ST_DONE;
        end
        ST_DONE: begin
          rsp_valid <= 1'b0;
          rsp_wr    <= 1'b0;
          rsp_trap  <= TRAP_NONE;
          rsp_data  <= '0;
          busy      <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/atomic_seq_chk.sv
module atomic_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              busy,
  input logic              rsp_valid,
  input logic              rsp_wr,
  input logic [1:0]        rsp_trap,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic              mem_lock,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [LANES-1:0]  mem_be,
  input logic              mem_ack,
  input logic              mem_err
);
  a_r3_lock_covers_access: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> mem_lock);

  a_r3_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  a_r3_write_follows_read: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && mem_ack && !mem_err) |=> (mem_wr && mem_lock));

  a_r3_unlock_after_write: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && mem_ack) |=> !mem_lock);

  a_r7_error_skips_write: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && mem_ack && mem_err) |=> (!mem_wr && !mem_lock));

  a_r4_read_after_grant: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd) |-> $past(mem_gnt));

  a_r4_req_while_locked: assert property (@(posedge clk) disable iff (rst)
    mem_lock |-> mem_req);

  a_r1_write_enables: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> ($countones(mem_be) == 1 || mem_be == '1));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req && !mem_lock && !rsp_valid));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r5_trap_no_write: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_trap != 2'd0) |-> !rsp_wr);

  a_r10_ok_writes_reg: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_trap == 2'd0) |-> rsp_wr);
endmodule

bind atomic_seq atomic_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/atomic_seq_tb.sv
`timescale 1ns/1ps
module atomic_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_op = 1'b0, req_alt = 1'b0, supervisor = 1'b0;
  logic [31:0] req_addr = '0, req_data = '0;
  logic        busy, rsp_valid, rsp_wr;
  logic [1:0]  rsp_trap;
  logic [31:0] rsp_data;
  logic        mem_req, mem_lock, mem_rd, mem_wr, mem_alt;
  logic        mem_gnt = 1'b0, mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0]  mem_be;

  always #2.5 clk = ~clk;

  atomic_seq u_dut (.*);

  logic [31:0] mem [16];
  logic [31:0] ref_mem [16];
  logic [3:0]  last_be = '0;
  int          dly = 0, wr_count = 0, rsp_count = 0;
  int          lock_viol = 0, gnt_viol = 0, cycles = 0;
  bit          err_mode = 1'b0, gnt_seen = 1'b0;
  int          n_checks = 0, n_fail = 0;

  // memory model: one-cycle ack, gap after each ack, random latency
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end else if (mem_rd || mem_wr) begin
      if (dly != 0) dly <= dly - 1;
      else begin
        mem_ack <= 1'b1;
        dly     <= int'($urandom % 3);
        if (mem_rd) begin
          mem_rdata <= mem[mem_addr[5:2]];
          mem_err   <= err_mode;
        end else begin
          for (int i = 0; i < 4; i++)
            if (mem_be[i]) mem[mem_addr[5:2]][8*i +: 8] <= mem_wdata[8*i +: 8];
          last_be  <= mem_be;
          wr_count <= wr_count + 1;
        end
      end
    end
  end

  // arbiter: grant after random delay
  always @(posedge clk)
    mem_gnt <= rst ? 1'b0 : (mem_req && ($urandom % 3 != 0));

  // protocol monitors
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst) begin
      if ((mem_rd || mem_wr) && !mem_lock) lock_viol <= lock_viol + 1;
      if (mem_rd && !gnt_seen) gnt_viol <= gnt_viol + 1;
      if (!mem_req) gnt_seen <= 1'b0;
      else if (mem_gnt) gnt_seen <= 1'b1;
      if (rsp_valid) rsp_count <= rsp_count + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_trap(bit op, bit alt, bit sup, logic [31:0] a, bit err);
    if (alt && !sup) return 2'd1;
    if (op && a[1:0] != 2'b00) return 2'd2;
    if (err) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [31:0] exp_res(bit op, logic [1:0] off, logic [31:0] w);
    if (op) return w;
    return {24'h0, w[8*(3-off) +: 8]};
  endfunction

  function automatic logic [31:0] exp_word(bit op, logic [1:0] off, logic [31:0] w, logic [31:0] d);
    logic [31:0] r = w;
    if (op) return d;
    r[8*(3-off) +: 8] = 8'hFF;
    return r;
  endfunction

  task automatic do_op(input bit op, input bit alt, input bit sup,
                       input logic [31:0] addr, input logic [31:0] data, input bit err);
    int          idx   = int'(addr[5:2]);
    int          oidx  = idx ^ 1;
    logic [31:0] w     = ref_mem[idx];
    logic [31:0] ow    = ref_mem[oidx];
    logic [1:0]  tr    = exp_trap(op, alt, sup, addr, err);
    logic [31:0] res   = (tr == 2'd0) ? exp_res(op, addr[1:0], w) : 32'h0;
    logic [31:0] nw    = (tr == 2'd0) ? exp_word(op, addr[1:0], w, data) : w;
    bit          goes  = (tr == 2'd0 || tr == 2'd3);
    logic [3:0]  ebe   = op ? 4'hF : 4'(1 << (3 - addr[1:0]));
    int          wr0   = wr_count;
    int          rsp0  = rsp_count;
    @(negedge clk);
    check(!busy, "R8", "busy before request", 32'(busy), 0);
    err_mode   = err;
    req_valid  = 1'b1; req_op = op; req_alt = alt; supervisor = sup;
    req_addr   = addr; req_data = data;
    @(negedge clk);
    check(busy, "R8", "busy after accept", 32'(busy), 1);
    // stray request while busy: must be refused
    req_op = 1'b1; req_alt = 1'b0; req_addr = 32'(oidx << 2); req_data = 32'hDEAD_BEEF;
    while (!rsp_valid) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
    req_valid = 1'b0;
    check(rsp_trap == tr, tr == 2'd1 ? "R5" : tr == 2'd2 ? "R6" : tr == 2'd3 ? "R7" : "R10",
          "trap code", 32'(rsp_trap), 32'(tr));
    check(rsp_wr == (tr == 2'd0), "R10", "register write flag", 32'(rsp_wr), 32'(tr == 2'd0));
    check(rsp_data == res, op ? "R2" : "R1", "result", rsp_data, res);
    check(busy, "R8", "busy with response", 32'(busy), 1);
    @(negedge clk);
    check(!busy, "R8", "busy after response", 32'(busy), 0);
    check(mem[idx] == nw, op ? "R2" : "R1", "memory word", mem[idx], nw);
    check(mem[oidx] == ow, "R8", "stray target untouched", mem[oidx], ow);
    check(rsp_count - rsp0 == 1, "R8", "responses per op", 32'(rsp_count - rsp0), 1);
    check(wr_count - wr0 == int'(tr == 2'd0), "R3", "writes per op",
          32'(wr_count - wr0), 32'(tr == 2'd0));
    if (tr == 2'd0)
      check(last_be == ebe, "R1", "byte enables", 32'(last_be), 32'(ebe));
    if (!goes)
      check(gnt_seen == 1'b0 && mem_req == 1'b0, "R6", "no bus request on trap", 32'(mem_req), 0);
    ref_mem[idx] = nw;
    err_mode = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) begin
      mem[i]     = $urandom;
      ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check(!busy && !mem_req && !mem_lock && !mem_rd && !mem_wr && !rsp_valid,
          "R9", "outputs in reset", {26'h0, busy, mem_req, mem_lock, mem_rd, mem_wr, rsp_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !mem_req && !mem_lock && !rsp_valid,
          "R9", "outputs after reset", {28'h0, busy, mem_req, mem_lock, rsp_valid}, 0);
    // directed corners
    for (int k = 0; k < 4; k++) do_op(1'b0, 1'b0, 1'b0, 32'h10 + 32'(k), 32'h0, 1'b0); // R1 each lane
    do_op(1'b0, 1'b0, 1'b0, 32'h11, 32'h0, 1'b0);               // R1 byte already 0xFF
    do_op(1'b1, 1'b0, 1'b0, 32'h20, 32'hCAFE_F00D, 1'b0);      // R2 aligned swap
    do_op(1'b1, 1'b0, 1'b0, 32'h23, 32'h1234_5678, 1'b0);      // R6 misaligned swap
    do_op(1'b0, 1'b0, 1'b0, 32'h23, 32'h0, 1'b0);              // R6 byte never misaligned
    do_op(1'b0, 1'b1, 1'b0, 32'h30, 32'h0, 1'b0);              // R5 unprivileged alt
    do_op(1'b1, 1'b1, 1'b1, 32'h30, 32'hA5A5_5A5A, 1'b0);      // R5 privileged alt ok
    do_op(1'b1, 1'b1, 1'b0, 32'h31, 32'h0, 1'b0);              // R6 priority: privilege first
    do_op(1'b1, 1'b0, 1'b0, 32'h08, 32'h7777_7777, 1'b1);      // R7 read error
    do_op(1'b0, 1'b0, 1'b0, 32'h0A, 32'h0, 1'b1);              // R7 read error byte
    // constrained random mix
    for (int n = 0; n < 200; n++) begin
      bit          op  = 1'($urandom);
      bit          alt = ($urandom % 4) == 0;
      bit          sup = ($urandom % 3) != 0;
      bit          er  = ($urandom % 8) == 0;
      logic [31:0] a   = {26'h0, 6'($urandom)};
      if (op && ($urandom % 4) != 0) a[1:0] = 2'b00;
      do_op(op, alt, sup, a, $urandom, er);
    end
    check(lock_viol == 0, "R3", "access without lock", 32'(lock_viol), 0);
    check(gnt_viol == 0, "R4", "read without grant", 32'(gnt_viol), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule